// File: doc/BRIEF.md
# Serial PCM Audio Capture Framer

This block receives serial PCM audio on three wires (bit clock, a word-select or frame-sync line, and serial data) and turns it into a stream of parallel samples. Two framing styles are accepted. The first is two-channel I2S, where the word-select level names the channel. The second is multi-slot TDM, where a one-bit sync pulse opens a frame of fixed-width slots. The word length and, for TDM, the channel count come from static configuration inputs. The design does not depend on any particular sample rate or bit-clock ratio. All three serial inputs are oversampled by the system clock. Only the rising edges of the bit clock advance the capture logic.

Every captured sample leaves the block left-aligned in a 24-bit word. It is tagged with its channel index, a two-bit subframe marker code and one channel-status bit. A 192-frame block counter selects both the marker and the status bit. The status bits come from a 40-bit configuration word, and the channel-number field is filled in for each channel. A downstream packetiser consumes the stream one sample at a time. If a TDM frame is cut short, a sticky error output is raised.

Top module: `aud_capture_framer`

## Requirements
- R1: After reset the sample valid, data, channel, marker, status and error outputs are all zero, and the block counter is at frame 0.
- R2: In I2S mode (`tdm_mode_i`=0), a change of `lrfs_i` sampled on a bit-clock rising edge starts a word. The word's MSB is taken on the next rising edge. `lrfs_i` low gives channel 0 and high gives channel 1. Channel 1 closes a frame.
- R3: In TDM mode (`tdm_mode_i`=1), the rising edge on which `lrfs_i` is high carries the MSB of slot 0. Each slot is 32 bit clocks long and slot n gives channel n. `chan_sel_i` sets the channel count: 0=2, 1=4, 2=6, 3=8. Slots at or beyond that count produce no sample.
- R4: `wlen_sel_i` sets the word length: 0=16, 1=18, 2=20, 3=24 bits. The first that-many bits of a word are captured MSB first. They are placed in the top bits of `smp_data_o`, and the bits below are zero.
- R5: `smp_pre_o` is 2'b01 for channel 0 in block frame 0, 2'b10 for channel 0 in any other frame, and 2'b11 for every other channel. 2'b00 never appears with a valid sample.
- R6: The block frame counter advances after the highest configured channel of a frame has been output. It wraps from 191 to 0.
- R7: For block frame f, `smp_cs_o` is bit (f-20) of (channel+1) when 20<=f<=23. Otherwise it is `cs_cfg_i[f]` when f<40, and 0 for f>=40.
- R8: In TDM mode, a sync pulse that arrives after the first one sets `frame_err_o` if fewer samples than the channel count were output since the previous sync. The flag stays set until reset. I2S traffic never sets it.
- R9: `smp_valid_o` is a one-cycle pulse, with exactly one pulse per captured sample. This holds for any bit-clock period whose high and low phases each last at least three system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock, data valid on its rising edge |
| lrfs_i | input | 1 | Word select (I2S) or frame-sync pulse (TDM) |
| sdata_i | input | 1 | Serial audio data, MSB first |
| tdm_mode_i | input | 1 | 0 selects I2S framing, 1 selects TDM framing |
| chan_sel_i | input | 2 | TDM channel count code |
| wlen_sel_i | input | 2 | Word length code |
| cs_cfg_i | input | 40 | Channel-status bits for block frames 0..39 |
| smp_valid_o | output | 1 | One-cycle strobe marking a new sample |
| smp_data_o | output | 24 | Left-aligned sample word |
| smp_chan_o | output | 3 | Channel index of the sample |
| smp_pre_o | output | 2 | Subframe marker code |
| smp_cs_o | output | 1 | Channel-status bit for this sample |
| frame_err_o | output | 1 | Sticky short-TDM-frame error |

## Verification
Each internal counter shows up at the ports in its own way, and at its own speed:

- **Bit position count:** if it slips, the data word of the very next sample is shifted, within one slot time.
- **Slot count:** if it is wrong, the channel tag is wrong, or a sample disappears or is extra when ignored slots are present. The scoreboard sees this within one frame.
- **Block frame counter:** a fault shows in the marker and status bits of the next frame. A fault in its wrap only shows after 192 frames, so one stimulus run covers more than a full block.

A missed or extra sample count in TDM turns up as a wrong error flag at the next sync pulse.

// File: rtl/aud_pkg.sv
package aud_pkg;

    typedef enum logic [1:0] {
        PRE_NONE  = 2'b00,
        PRE_BLOCK = 2'b01,
        PRE_FIRST = 2'b10,
        PRE_OTHER = 2'b11
    } pre_e;

    // word length in bits for a length code
    function automatic logic [5:0] wlen_of(input logic [1:0] sel);
        logic [5:0] r;
        case (sel)
            2'd0:    r = 6'd16;
            2'd1:    r = 6'd18;
            2'd2:    r = 6'd20;
            default: r = 6'd24;
        endcase
        return r;
    endfunction

    // channel count for a TDM channel code: 2, 4, 6 or 8
    function automatic logic [3:0] chans_of(input logic [1:0] sel);
        return {1'b0, sel, 1'b0} + 4'd2;
    endfunction

endpackage

// File: rtl/aud_pin_sync.sv
module aud_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrfs_i,
    input  logic sdata_i,
    output logic bit_stb_o,
    output logic lrfs_o,
    output logic sdata_o
);

    typedef struct packed {
        logic [STAGES-1:0] b;
        logic [STAGES-1:0] l;
        logic [STAGES-1:0] s;
        logic              prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.b    = {q.b[STAGES-2:0], bclk_i};
        d.l    = {q.l[STAGES-2:0], lrfs_i};
        d.s    = {q.s[STAGES-2:0], sdata_i};
        d.prev = q.b[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_stb_o = q.b[STAGES-1] & ~q.prev;
    assign lrfs_o    = q.l[STAGES-1];
    assign sdata_o   = q.s[STAGES-1];

    // strobes from a real clock edge can never be back to back
    assert_strobe_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |=> !bit_stb_o);

endmodule

// File: rtl/aud_deser.sv
module aud_deser #(
    parameter int SMP_W  = 24,
    parameter int SLOT_W = 32,
    parameter int MAX_CH = 8,
    localparam int POS_W = $clog2(SLOT_W) + 1,
    localparam int CNT_W = $clog2(MAX_CH) + 1,
    localparam int CH_W  = $clog2(MAX_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb_i,
    input  logic             lrfs_i,
    input  logic             sd_i,
    input  logic             tdm_i,
    input  logic [CNT_W-1:0] nch_i,
    input  logic [POS_W-1:0] wlen_i,
    output logic             w_valid_o,
    output logic [SMP_W-1:0] w_data_o,
    output logic [CH_W-1:0]  w_chan_o,
    output logic             w_last_o,
    output logic             err_o
);

    typedef struct packed {
        logic [SMP_W-1:0] shreg;
        logic [POS_W-1:0] pos;     // SLOT_W means idle
        logic [CNT_W-1:0] slot;
        logic [CNT_W-1:0] got;     // samples output since last sync
        logic             started;
        logic             err;
        logic             lr_prev;
        logic             ov;
        logic [SMP_W-1:0] odata;
        logic [CH_W-1:0]  ochan;
        logic             olast;
    } des_t;

    des_t q, d;

    logic             cap, take;
    logic [POS_W-1:0] cur_pos;
    logic [CNT_W-1:0] cur_slot, got_base;
    logic [SMP_W-1:0] sh_in;

    always_comb begin
        d        = q;
        d.ov     = 1'b0;
        cap      = 1'b0;
        cur_pos  = q.pos;
        cur_slot = q.slot;
        got_base = q.got;
        sh_in    = q.shreg;

        if (bit_stb_i) begin
            d.lr_prev = lrfs_i;
            if (!tdm_i) begin
                if (lrfs_i != q.lr_prev) begin
                    d.pos  = '0;
                    d.slot = CNT_W'(lrfs_i);
                end else if (q.pos < POS_W'(SLOT_W)) begin
                    cap   = 1'b1;
                    d.pos = q.pos + 1'b1;
                end
            end else if (lrfs_i) begin
                if (q.started && (q.got < nch_i)) d.err = 1'b1;
                d.started = 1'b1;
                cap       = 1'b1;
                cur_pos   = '0;
                cur_slot  = '0;
                got_base  = '0;
                d.slot    = '0;
                d.pos     = POS_W'(1);
            end else if (q.pos < POS_W'(SLOT_W)) begin
                cap = 1'b1;
                if (q.pos == POS_W'(SLOT_W - 1)) begin
                    d.pos = '0;
                    if (q.slot < CNT_W'(MAX_CH)) d.slot = q.slot + 1'b1;
                end else begin
                    d.pos = q.pos + 1'b1;
                end
            end
        end

        d.got = got_base;
        take  = cap && (cur_slot < nch_i) && (cur_pos < wlen_i);
        if (take) begin
            sh_in   = (cur_pos == '0) ? SMP_W'(sd_i) : {q.shreg[SMP_W-2:0], sd_i};
            d.shreg = sh_in;
            if (cur_pos == wlen_i - 1'b1) begin
                d.ov    = 1'b1;
                d.odata = sh_in << (SMP_W - int'(wlen_i));
                d.ochan = cur_slot[CH_W-1:0];
                d.olast = (cur_slot == nch_i - 1'b1);
                d.got   = got_base + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.pos <= POS_W'(SLOT_W);
        end else begin
            q <= d;
        end
    end

    assign w_valid_o = q.ov;
    assign w_data_o  = q.odata;
    assign w_chan_o  = q.ochan;
    assign w_last_o  = q.olast;
    assign err_o     = q.err;

    logic [SMP_W-1:0] low_mask;
    assign low_mask = (SMP_W'(1) << (SMP_W - int'(wlen_i))) - 1'b1;

    assert_chan_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid_o |-> (CNT_W'(w_chan_o) < nch_i));
    assert_low_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid_o |-> ((w_data_o & low_mask) == '0));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    assert_one_cycle_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid_o |=> !w_valid_o);

endmodule

// File: rtl/aud_cs_tagger.sv
module aud_cs_tagger
    import aud_pkg::*;
#(
    parameter int SMP_W     = 24,
    parameter int CH_W      = 3,
    parameter int CS_LEN    = 192,
    parameter int CS_CFG_W  = 40,
    parameter int CHNUM_POS = 20,
    localparam int FRM_W    = $clog2(CS_LEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                w_valid_i,
    input  logic [SMP_W-1:0]    w_data_i,
    input  logic [CH_W-1:0]     w_chan_i,
    input  logic                w_last_i,
    input  logic [CS_CFG_W-1:0] cs_cfg_i,
    output logic                s_valid_o,
    output logic [SMP_W-1:0]    s_data_o,
    output logic [CH_W-1:0]     s_chan_o,
    output logic [1:0]          s_pre_o,
    output logic                s_cs_o
);

    typedef struct packed {
        logic             ov;
        logic [SMP_W-1:0] data;
        logic [CH_W-1:0]  chan;
        pre_e             pre;
        logic             cs;
        logic [FRM_W-1:0] frame;
    } tag_t;

    tag_t q, d;

    logic [3:0] chnum;
    logic       cs_bit;
    int         fidx;

    always_comb begin
        chnum = 4'(w_chan_i) + 4'd1;
        fidx  = int'(q.frame);
        if (fidx >= CHNUM_POS && fidx < CHNUM_POS + 4) cs_bit = chnum[fidx - CHNUM_POS];
        else if (fidx < CS_CFG_W)                      cs_bit = cs_cfg_i[fidx];
        else                                           cs_bit = 1'b0;
    end

    always_comb begin
        d    = q;
        d.ov = 1'b0;
        if (w_valid_i) begin
            d.ov   = 1'b1;
            d.data = w_data_i;
            d.chan = w_chan_i;
            d.cs   = cs_bit;
            if (w_chan_i != '0)     d.pre = PRE_OTHER;
            else if (q.frame == '0) d.pre = PRE_BLOCK;
            else                    d.pre = PRE_FIRST;
            if (w_last_i)
                d.frame = (q.frame == FRM_W'(CS_LEN - 1)) ? '0 : q.frame + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.pre <= PRE_NONE;
        end else begin
            q <= d;
        end
    end

    assign s_valid_o = q.ov;
    assign s_data_o  = q.data;
    assign s_chan_o  = q.chan;
    assign s_pre_o   = q.pre;
    assign s_cs_o    = q.cs;

    assert_pre_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid_o |-> (s_pre_o != PRE_NONE));
    assert_block_on_chan0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid_o && s_pre_o == PRE_BLOCK) |-> (s_chan_o == '0));
    assert_frame_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.frame < FRM_W'(CS_LEN));

endmodule

// File: rtl/aud_capture_framer.sv
module aud_capture_framer
    import aud_pkg::*;
#(
    parameter int SMP_W       = 24,
    parameter int SLOT_W      = 32,
    parameter int MAX_CH      = 8,
    parameter int CS_LEN      = 192,
    parameter int CS_CFG_W    = 40,
    parameter int CHNUM_POS   = 20,
    parameter int SYNC_STAGES = 2,
    localparam int POS_W      = $clog2(SLOT_W) + 1,
    localparam int CNT_W      = $clog2(MAX_CH) + 1,
    localparam int CH_W       = $clog2(MAX_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                lrfs_i,
    input  logic                sdata_i,
    input  logic                tdm_mode_i,
    input  logic [1:0]          chan_sel_i,
    input  logic [1:0]          wlen_sel_i,
    input  logic [CS_CFG_W-1:0] cs_cfg_i,
    output logic                smp_valid_o,
    output logic [SMP_W-1:0]    smp_data_o,
    output logic [CH_W-1:0]     smp_chan_o,
    output logic [1:0]          smp_pre_o,
    output logic                smp_cs_o,
    output logic                frame_err_o
);

    logic             bit_stb, lr_s, sd_s;
    logic [CNT_W-1:0] nch;
    logic [POS_W-1:0] wlen;
    logic             w_valid, w_last;
    logic [SMP_W-1:0] w_data;
    logic [CH_W-1:0]  w_chan;

    assign nch  = tdm_mode_i ? CNT_W'(chans_of(chan_sel_i)) : CNT_W'(2);
    assign wlen = POS_W'(wlen_of(wlen_sel_i));

    aud_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk_i),
        .lrfs_i    (lrfs_i),
        .sdata_i   (sdata_i),
        .bit_stb_o (bit_stb),
        .lrfs_o    (lr_s),
        .sdata_o   (sd_s)
    );

    aud_deser #(.SMP_W(SMP_W), .SLOT_W(SLOT_W), .MAX_CH(MAX_CH)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb_i (bit_stb),
        .lrfs_i    (lr_s),
        .sd_i      (sd_s),
        .tdm_i     (tdm_mode_i),
        .nch_i     (nch),
        .wlen_i    (wlen),
        .w_valid_o (w_valid),
        .w_data_o  (w_data),
        .w_chan_o  (w_chan),
        .w_last_o  (w_last),
        .err_o     (frame_err_o)
    );

    aud_cs_tagger #(.SMP_W(SMP_W), .CH_W(CH_W), .CS_LEN(CS_LEN),
                    .CS_CFG_W(CS_CFG_W), .CHNUM_POS(CHNUM_POS)) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .w_valid_i (w_valid),
        .w_data_i  (w_data),
        .w_chan_i  (w_chan),
        .w_last_i  (w_last),
        .cs_cfg_i  (cs_cfg_i),
        .s_valid_o (smp_valid_o),
        .s_data_o  (smp_data_o),
        .s_chan_o  (smp_chan_o),
        .s_pre_o   (smp_pre_o),
        .s_cs_o    (smp_cs_o)
    );

    assert_i2s_chan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && !tdm_mode_i) |-> (smp_chan_o < CH_W'(2)));

endmodule

// File: tb/sim_aud_capture_framer.sv
`timescale 1ns/1ps
module sim_aud_capture_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, lrfs = 1'b0, sdata = 1'b0;
    logic        tdm_mode = 1'b0;
    logic [1:0]  chan_sel = 2'd0, wlen_sel = 2'd3;
    logic [39:0] cs_cfg = '0;
    logic        smp_valid, smp_cs, frame_err;
    logic [23:0] smp_data;
    logic [2:0]  smp_chan;
    logic [1:0]  smp_pre;

    always #2.5 clk = ~clk;

    aud_capture_framer u0 (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrfs_i(lrfs), .sdata_i(sdata),
        .tdm_mode_i(tdm_mode), .chan_sel_i(chan_sel), .wlen_sel_i(wlen_sel),
        .cs_cfg_i(cs_cfg), .smp_valid_o(smp_valid), .smp_data_o(smp_data),
        .smp_chan_o(smp_chan), .smp_pre_o(smp_pre), .smp_cs_o(smp_cs),
        .frame_err_o(frame_err)
    );

    typedef struct {
        logic [23:0] d;
        int          ch;
        int          pre;
        bit          cs;
    } exp_t;

    exp_t eq[$];
    int   checks = 0, errors = 0;
    int   exp_frame = 0;
    int   half_per = 3;

    function automatic int wl_of(input logic [1:0] s);
        return (s == 2'd0) ? 16 : (s == 2'd1) ? 18 : (s == 2'd2) ? 20 : 24;
    endfunction

    function automatic int nch_of(input logic [1:0] s);
        return 2 * (int'(s) + 1);
    endfunction

    function automatic bit cs_model(input int f, input int ch);
        if (f >= 20 && f < 24) return bit'(((ch + 1) >> (f - 20)) & 1);
        if (f < 40)            return cs_cfg[f];
        return 1'b0;
    endfunction

    task automatic push_exp(input logic [23:0] raw, input int wl, input int ch, input int nch);
        exp_t e;
        logic [23:0] m;
        m    = (24'd1 << wl) - 24'd1;
        e.d  = (raw & m) << (24 - wl);
        e.ch = ch;
        e.pre = (ch != 0) ? 3 : ((exp_frame == 0) ? 1 : 2);
        e.cs = cs_model(exp_frame, ch);
        eq.push_back(e);
        if (ch == nch - 1) exp_frame = (exp_frame + 1) % 192;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare each sample against the scoreboard
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            if (eq.size() == 0) begin
                chk(1'b0, "R9 unexpected sample (R3 ignored slot)", int'(smp_data), 0);
            end else begin
                exp_t e;
                e = eq.pop_front();
                chk(smp_data == e.d, tdm_mode ? "R3/R4 data" : "R2/R4 data", int'(smp_data), int'(e.d));
                chk(int'(smp_chan) == e.ch, tdm_mode ? "R3 channel" : "R2 channel", int'(smp_chan), e.ch);
                chk(int'(smp_pre) == e.pre, "R5/R6 marker", int'(smp_pre), e.pre);
                chk(smp_cs == e.cs, "R7 status bit", int'(smp_cs), int'(e.cs));
            end
        end
    end

    // one serial bit: drive while bclk low, then raise bclk
    task automatic send_bit(input logic lr, input logic d);
        bclk = 1'b0; lrfs = lr; sdata = d;
        repeat (half_per) @(negedge clk);
        bclk = 1'b1;
        repeat (half_per) @(negedge clk);
    endtask

    task automatic send_i2s(input logic [23:0] l, input logic [23:0] r);
        int wl;
        logic [23:0] w;
        wl = wl_of(wlen_sel);
        push_exp(l, wl, 0, 2);
        push_exp(r, wl, 1, 2);
        for (int h = 0; h < 2; h++) begin
            w = (h == 0) ? l : r;
            for (int b = 0; b < 32; b++)
                send_bit(logic'(h), (b >= 1 && b <= wl) ? w[wl - b] : 1'b0);
        end
    endtask

    task automatic send_tdm(input int slots, input logic [23:0] w [8]);
        int wl, nch;
        wl  = wl_of(wlen_sel);
        nch = nch_of(chan_sel);
        for (int s = 0; s < slots; s++)
            if (s < nch) push_exp(w[s], wl, s, nch);
        for (int s = 0; s < slots; s++)
            for (int b = 0; b < 32; b++)
                send_bit(logic'(s == 0 && b == 0), (b < wl) ? w[s][wl - 1 - b] : 1'b0);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; bclk = 1'b0; lrfs = 1'b0; sdata = 1'b0;
        eq.delete();
        exp_frame = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!smp_valid && smp_data == '0 && smp_pre == 2'b00 && smp_chan == '0 && !smp_cs,
            "R1 outputs after reset", {smp_valid, smp_pre, smp_chan, smp_cs}, 0);
        chk(!frame_err, "R1 error flag after reset", int'(frame_err), 0);
    endtask

    task automatic drain(input string tag);
        repeat (20) @(negedge clk);
        chk(eq.size() == 0, tag, eq.size(), 0);
    endtask

    task automatic rand_tdm_frame(input int slots);
        logic [23:0] w [8];
        for (int i = 0; i < 8; i++) w[i] = 24'($urandom);
        send_tdm(slots, w);
    endtask

    initial begin
        void'($urandom(32'd20517));
        cs_cfg = {8'($urandom), 32'($urandom)};

        // ---- I2S: two directed frames, then random ones past the block wrap
        tdm_mode = 1'b0;
        do_reset();
        half_per = 3;
        for (int b = 0; b < 8; b++) send_bit(1'b1, 1'b1); // short stub: no sample
        wlen_sel = 2'd3;
        send_i2s(24'hFFFFFF, 24'h800000);                   // R4 full 24-bit words
        wlen_sel = 2'd0;
        send_i2s(24'h00FFFF, 24'h000001);                   // R4 16-bit extremes
        for (int f = 2; f < 194; f++) begin                 // R6 wrap at 192
            wlen_sel = 2'($urandom % 4);
            send_i2s(24'($urandom), 24'($urandom));
        end
        drain("R9 I2S samples missing");
        chk(!frame_err, "R8 I2S never flags", int'(frame_err), 0);

        // ---- TDM: descending channel counts, 8 slots of data per frame
        tdm_mode = 1'b1;
        do_reset();
        for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b1); // idle before first sync
        for (int k = 0; k < 8; k++) begin
            half_per = 4 + (k % 2);                         // R9 rate independence
            chan_sel = 2'(3 - k / 2);
            wlen_sel = 2'($urandom % 4);
            rand_tdm_frame(8);
        end
        send_bit(1'b1, 1'b0);                               // closing sync
        drain("R3 TDM samples missing");
        chk(!frame_err, "R8 complete frames keep flag low", int'(frame_err), 0);

        // ---- TDM short frame
        do_reset();
        half_per = 4;
        chan_sel = 2'd1;                                    // 4 channels
        wlen_sel = 2'd2;
        rand_tdm_frame(4);
        chk(!frame_err, "R8 first full frame", int'(frame_err), 0);
        rand_tdm_frame(2);                                  // short frame
        chk(!frame_err, "R8 flag waits for next sync", int'(frame_err), 0);
        rand_tdm_frame(4);
        chk(frame_err, "R8 short frame flagged", int'(frame_err), 1);
        rand_tdm_frame(4);
        send_bit(1'b1, 1'b0);
        repeat (10) @(negedge clk);
        chk(frame_err, "R8 flag is sticky", int'(frame_err), 1);
        drain("R9 samples missing after short frame");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule